// File: doc/BRIEF.md
# Windowed Integer Register File

This block is a 32-bit general-purpose register file in which a running program sees a 24-register window into a larger circular physical stack, plus eight global registers shared by all windows. Instructions name registers with 5-bit specifiers. A current-window pointer turns each specifier into a physical index. Each cycle the file serves two combinational read ports and one write port.

Adjacent windows overlap. The eight outgoing registers of one window are the same storage as the eight incoming registers of the window one step below it. A save pulse moves the pointer down one window, so a caller's outgoing arguments appear as the callee's incoming ones. A restore pulse moves it back up. Both moves wrap around the stack.

An externally held invalid mask marks windows that are still occupied. A save or restore that would enter such a window raises an overflow or underflow flag and leaves the pointer where it was. Spilling windows to memory and handling the resulting trap belong to other logic.

Top module: `win_regfile`

## Requirements
- R1: While rst_ni is low the pointer is 0 and both flags are low, and every register is cleared. After reset, every specifier in every window reads 0 until it is written.
- R2: Specifiers 0 to 7 select the global registers. Each global is one physical register, whatever the pointer value.
- R3: Global 0 always reads as 0. A write to specifier 0 has no effect, including on the forwarding path.
- R4: Specifiers 16 to 23 (local) and 24 to 31 (in) select storage owned by the current window alone. A write to them is seen from no other window, except through the out alias of R5.
- R5: Specifier 8+k (out, k = 0..7) in window w is the same physical register as specifier 24+k (in) in window (w-1) mod NWIN.
- R6: When the target window is valid, a save pulse sets cwp_o to (cwp_o-1) mod NWIN at the next clock edge, and a restore pulse sets it to (cwp_o+1) mod NWIN. With no pulse the pointer holds.
- R7: A save whose target window has its inv_mask_i bit set raises overflow_o for exactly the following cycle and leaves cwp_o unchanged.
- R8: A restore whose target window has its inv_mask_i bit set raises underflow_o for exactly the following cycle and leaves cwp_o unchanged.
- R9: When save_i and restore_i are both high, the save is performed (or flagged) and the restore is ignored.
- R10: Reads are combinational. When a write targets the same physical register as a read in the same cycle, the read port returns wdata_i.
- R11: A write takes effect at the clock edge and is placed using the pointer value from before any window move in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| save_i | input | 1 | Move to the window below |
| restore_i | input | 1 | Move to the window above |
| inv_mask_i | input | NWIN | One bit per window; 1 = occupied, entry is refused |
| rs1_i | input | 5 | Read specifier, port 1 |
| rs2_i | input | 5 | Read specifier, port 2 |
| rdata1_o | output | XLEN | Read data, port 1 |
| rdata2_o | output | XLEN | Read data, port 2 |
| we_i | input | 1 | Write enable |
| rd_i | input | 5 | Write specifier |
| wdata_i | input | XLEN | Write data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Refused save, one-cycle pulse |
| underflow_o | output | 1 | Refused restore, one-cycle pulse |

## Verification
The bench uses a four-window build. It writes a distinct value to every specifier of every window, then reads every window back through both ports. A wrong out/in alias, or an out group tied to the window above instead of the one below, shows up as values appearing in the wrong window. It drives saves and restores across the wrap in both directions; an unwrapped pointer would leave the stack or land on a nonexistent window. It also sets invalid bits so that saves and restores are refused, with and without a simultaneous opposite pulse. A design that moved anyway, held the flag too long or let restore win would show a wrong pointer or a wrong flag. Finally it writes during a window move and during a same-cycle read. A design that used the new pointer for the write, or left out forwarding, would return stale data.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned SPEC_W  = 5;
  localparam int unsigned N_GLB   = 8;
  localparam int unsigned GRP_SZ  = 8;
  localparam int unsigned SET_SZ  = 16;  // locals then ins per window

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'b00,
    GRP_OUT    = 2'b01,
    GRP_LOCAL  = 2'b10,
    GRP_IN     = 2'b11
  } reg_grp_e;

  function automatic reg_grp_e spec_group(input logic [SPEC_W-1:0] spec);
    return reg_grp_e'(spec[4:3]);
  endfunction
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [SPEC_W-1:0] spec_i,
  output logic [PW-1:0]     phys_o
);
  logic [CW-1:0] below_w;
  int unsigned   off;

  always_comb begin
    below_w = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - CW'(1);
    off     = int'(spec_i[2:0]);
    unique case (spec_group(spec_i))
      GRP_GLOBAL: phys_o = PW'(off);
      // outs alias the ins of the window below
      GRP_OUT:    phys_o = PW'(N_GLB + SET_SZ * int'(below_w) + GRP_SZ + off);
      GRP_LOCAL:  phys_o = PW'(N_GLB + SET_SZ * int'(cwp_i) + off);
      GRP_IN:     phys_o = PW'(N_GLB + SET_SZ * int'(cwp_i) + GRP_SZ + off);
      default:    phys_o = '0;
    endcase
  end
endmodule

// File: rtl/wrf_cwp_ctrl.sv
module wrf_cwp_ctrl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [NWIN-1:0] inv_mask_i,
  output logic [CW-1:0]   cwp_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  logic [CW-1:0] cwp_q, cwp_d, dn_w, up_w;
  logic          ovf_d, unf_d, ovf_q, unf_q;

  always_comb begin
    dn_w  = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - CW'(1);
    up_w  = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + CW'(1);
    ovf_d = 1'b0;
    unf_d = 1'b0;
    cwp_d = cwp_q;
    if (save_i) begin  // save has priority
      if (inv_mask_i[dn_w]) ovf_d = 1'b1;
      else                  cwp_d = dn_w;
    end else if (restore_i) begin
      if (inv_mask_i[up_w]) unf_d = 1'b1;
      else                  cwp_d = up_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cwp_q <= cwp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o       = cwp_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned NREG = 136,
  parameter int unsigned PW   = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PW-1:0]   raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD],
  input  logic            we_i,
  input  logic [PW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] mem_q [NREG];
  logic            wr_ok;

  // physical 0 is global 0: never written
  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    always_comb begin
      if (wr_ok && (waddr_i == raddr_i[p])) rdata_o[p] = wdata_i;
      else                                  rdata_o[p] = mem_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned NREG = N_GLB + SET_SZ * NWIN,
  localparam int unsigned PW   = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [NWIN-1:0]   inv_mask_i,
  input  logic [SPEC_W-1:0] rs1_i,
  input  logic [SPEC_W-1:0] rs2_i,
  output logic [XLEN-1:0]   rdata1_o,
  output logic [XLEN-1:0]   rdata2_o,
  input  logic              we_i,
  input  logic [SPEC_W-1:0] rd_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [CW-1:0]     cwp_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int unsigned NMAP = 3;  // two reads, one write

  logic [CW-1:0]     cwp;
  logic [SPEC_W-1:0] spec_a [NMAP];
  logic [PW-1:0]     phys_a [NMAP];
  logic [PW-1:0]     raddr  [2];
  logic [XLEN-1:0]   rdata  [2];

  assign spec_a[0] = rs1_i;
  assign spec_a[1] = rs2_i;
  assign spec_a[2] = rd_i;

  wrf_cwp_ctrl #(.NWIN(NWIN), .CW(CW)) u_cwp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_i      (save_i),
    .restore_i   (restore_i),
    .inv_mask_i  (inv_mask_i),
    .cwp_o       (cwp),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  for (genvar m = 0; m < int'(NMAP); m++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .cwp_i  (cwp),
      .spec_i (spec_a[m]),
      .phys_o (phys_a[m])
    );
  end

  assign raddr[0] = phys_a[0];
  assign raddr[1] = phys_a[1];

  wrf_storage #(.NREG(NREG), .PW(PW), .XLEN(XLEN), .NRD(2)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (we_i),
    .waddr_i (phys_a[2]),
    .wdata_i (wdata_i)
  );

  assign rdata1_o = rdata[0];
  assign rdata2_o = rdata[1];
  assign cwp_o    = cwp;
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            save_i,
  input logic            restore_i,
  input logic [NWIN-1:0] inv_mask_i,
  input logic [4:0]      rs1_i,
  input logic [4:0]      rs2_i,
  input logic [XLEN-1:0] rdata1_o,
  input logic [XLEN-1:0] rdata2_o,
  input logic            we_i,
  input logic [4:0]      rd_i,
  input logic [XLEN-1:0] wdata_i,
  input logic [CW-1:0]   cwp_o,
  input logic            overflow_o,
  input logic            underflow_o
);
  logic [CW-1:0] dn_w, up_w;
  always_comb begin
    dn_w = (cwp_o == '0) ? CW'(NWIN - 1) : cwp_o - CW'(1);
    up_w = (cwp_o == CW'(NWIN - 1)) ? '0 : cwp_o + CW'(1);
  end

  AST_G0_ZERO_P1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_i == '0) |-> (rdata1_o == '0));  // R3
  AST_G0_ZERO_P2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs2_i == '0) |-> (rdata2_o == '0));  // R3
  AST_FWD_P1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rd_i != '0 && rs1_i == rd_i) |-> (rdata1_o == wdata_i));  // R10
  AST_SAVE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !inv_mask_i[dn_w]) |=> (cwp_o == $past(dn_w)));  // R6
  AST_RESTORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && restore_i && !inv_mask_i[up_w]) |=> (cwp_o == $past(up_w)));  // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i) |=> ($stable(cwp_o) && !overflow_o && !underflow_o));  // R6
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && inv_mask_i[dn_w]) |=> (overflow_o && $stable(cwp_o)));  // R7
  AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && restore_i && inv_mask_i[up_w]) |=> (underflow_o && $stable(cwp_o)));  // R8
  AST_SAVE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> !underflow_o);  // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && underflow_o));  // R9
endmodule

bind win_regfile wrf_checker #(.NWIN(NWIN), .XLEN(XLEN), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .inv_mask_i  (inv_mask_i),
  .rs1_i       (rs1_i),
  .rs2_i       (rs2_i),
  .rdata1_o    (rdata1_o),
  .rdata2_o    (rdata2_o),
  .we_i        (we_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .cwp_o       (cwp_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
  localparam int N    = 4;
  localparam int NPHY = 8 + 16 * N;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        save_i = 1'b0, restore_i = 1'b0, we_i = 1'b0;
  logic [N-1:0] inv_mask_i = '0;
  logic [4:0]  rs1_i = '0, rs2_i = '0, rd_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata1_o, rdata2_o;
  logic [1:0]  cwp_o;
  logic        overflow_o, underflow_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cwp = 0;
  logic [31:0] model [NPHY];

  always #10 clk_i = ~clk_i;  // 50 MHz

  win_regfile #(.NWIN(N), .XLEN(32)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pidx(input int w, input int s);
    if (s < 8)  return s;
    if (s < 16) return 8 + 16 * ((w + N - 1) % N) + 8 + (s - 8);
    if (s < 24) return 8 + 16 * w + (s - 16);
    return 8 + 16 * w + 8 + (s - 24);
  endfunction

  function automatic string grp_tag(input int s);
    if (s == 0) return "R3";
    if (s < 8)  return "R2";
    if (s < 16) return "R5";
    return "R4";
  endfunction

  task automatic wr(input int s, input logic [31:0] v);
    we_i = 1; rd_i = 5'(s); wdata_i = v;
    @(posedge clk_i); #2;
    we_i = 0;
    if (pidx(m_cwp, s) != 0) model[pidx(m_cwp, s)] = v;
  endtask

  task automatic rd_chk(input int s, input string req);
    rs1_i = 5'(s); rs2_i = 5'(31 - s);
    #1;
    chk(rdata1_o == model[pidx(m_cwp, s)], req, rdata1_o, model[pidx(m_cwp, s)]);
    chk(rdata2_o == model[pidx(m_cwp, 31 - s)], grp_tag(31 - s), rdata2_o, model[pidx(m_cwp, 31 - s)]);
  endtask

  task automatic move(input bit sv, input bit rs);
    int dn = (m_cwp + N - 1) % N;
    int up = (m_cwp + 1) % N;
    bit eo = sv && inv_mask_i[dn];
    bit eu = !sv && rs && inv_mask_i[up];
    string tag = (sv && rs) ? "R9" : eo ? "R7" : eu ? "R8" : "R6";
    if (sv && !eo) m_cwp = dn;
    else if (!sv && rs && !eu) m_cwp = up;
    save_i = sv; restore_i = rs;
    @(posedge clk_i); #2;
    save_i = 0; restore_i = 0;
    chk(cwp_o == 2'(m_cwp), tag, 32'(cwp_o), 32'(m_cwp));
    chk(overflow_o == eo, tag, 32'(overflow_o), 32'(eo));
    chk(underflow_o == eu, tag, 32'(underflow_o), 32'(eu));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPHY; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(cwp_o == 0, "R1", 32'(cwp_o), 0);
    chk(!overflow_o && !underflow_o, "R1", 32'({overflow_o, underflow_o}), 0);
    rst_ni = 1;
    #1;
    for (int w = 0; w < N; w++) begin
      for (int s = 0; s < 32; s++) begin
        rs1_i = 5'(s); #1;
        chk(rdata1_o == 0, "R1", rdata1_o, 0);
      end
      move(0, 1);
    end

    // fill every specifier of every window
    for (int w = 0; w < N; w++) begin
      for (int s = 0; s < 32; s++) wr(s, 32'hC0DE_0000 | 32'(w << 8) | 32'(s));
      move(0, 1);  // ends wrapped back to 0 (R6)
    end
    // read back every window on both ports
    for (int w = 0; w < N; w++) begin
      for (int s = 0; s < 32; s++) rd_chk(s, grp_tag(s));
      move(0, 1);
    end

    // R5: out of window 0 seen as in of window 3 after save wrap
    wr(11, 32'h1234_5678);
    move(1, 0);
    chk(cwp_o == 3, "R6", 32'(cwp_o), 3);
    rd_chk(27, "R5");
    move(0, 1);

    // R10: forwarding, and R3 no forwarding through global 0
    we_i = 1; rd_i = 19; wdata_i = 32'hDEAD_0019; rs1_i = 19; rs2_i = 0;
    #1;
    chk(rdata1_o == 32'hDEAD_0019, "R10", rdata1_o, 32'hDEAD_0019);
    chk(rdata2_o == 0, "R3", rdata2_o, 0);
    @(posedge clk_i); #2;
    model[pidx(m_cwp, 19)] = 32'hDEAD_0019;
    rd_i = 0; wdata_i = 32'hFFFF_FFFF; rs1_i = 0;
    #1;
    chk(rdata1_o == 0, "R3", rdata1_o, 0);
    @(posedge clk_i); #2;
    we_i = 0;
    rd_chk(0, "R3");

    // R11: write issued with a save uses the old window
    we_i = 1; rd_i = 16; wdata_i = 32'hBEEF_0016; save_i = 1;
    model[pidx(m_cwp, 16)] = 32'hBEEF_0016;
    m_cwp = (m_cwp + N - 1) % N;
    @(posedge clk_i); #2;
    we_i = 0; save_i = 0;
    rd_chk(16, "R11");
    move(0, 1);
    rd_chk(16, "R11");

    // R7: refused save and one-cycle flag
    inv_mask_i = 4'b1000;  // window 3 below window 0
    move(1, 0);
    move(0, 0);
    chk(!overflow_o, "R7", 32'(overflow_o), 0);
    // R9: both pulses with save refused: no restore either
    move(1, 1);
    inv_mask_i = 4'b0000;
    move(0, 1);  // to 1
    // R8: refused restore
    inv_mask_i = 4'b0100;
    move(0, 1);
    move(0, 0);
    chk(!underflow_o, "R8", 32'(underflow_o), 0);
    // R9: both pulses, save performed
    move(1, 1);
    chk(cwp_o == 0, "R9", 32'(cwp_o), 0);
    inv_mask_i = '0;

    // final sweep: nothing disturbed
    for (int w = 0; w < N; w++) begin
      for (int s = 0; s < 32; s++) rd_chk(s, grp_tag(s));
      move(0, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule